// File: doc/BRIEF.md
# Strided Transfer Descriptor Chain Builder

This block turns a two-dimensional transfer request into a linked list of 16-byte DMA descriptors in memory. A request names a start address in system memory, a start address on the device side, the number of bytes in each line, the number of lines, a system-memory stride and a signed device-side stride. The block checks the request against its size, stride and alignment rules. It then walks the rectangle line by line and cuts each line wherever it meets a 4096-byte boundary in system memory. For each piece it writes one descriptor, one 32-bit word per cycle, through a plain write port into a descriptor area whose base address is an input.

The chain is linked backwards. The first descriptor written ends the chain, and every later descriptor points to the one written just before it. The reported chain head is therefore the last descriptor written. A request whose two strides both equal the line length describes one contiguous block, so it is folded into a single long line before the walk begins. When the walk ends, a one-cycle done pulse carries the descriptor count, the chain head and an error flag.

Top module: `stride_desc_chain`

## Requirements
- R1: Descriptor n occupies the four words at base + 16*n + 0, +4, +8 and +12. In that order they hold the system-memory address, the device address, the byte count and the next pointer. Each word is written in its own cycle, at consecutive addresses.
- R2: A segment's byte count is the smaller of (4096 minus the memory address modulo 4096) and the bytes still left in the line. The next segment's memory address and device address both advance by that count.
- R3: At each new line the memory address is the previous line's start plus the memory stride. The device address is the previous line's start plus the device stride, taken as a two's-complement value, so a negative stride walks the device side backwards.
- R4: The next field of descriptor 0 is 0x00000002, the end-of-chain flag in bit 1. The next field of descriptor n > 0 is base + 16*(n-1). On success the reported head is base + 16*(count-1).
- R5: When the memory stride and the device stride both equal the line length, the request becomes one line of length (line length × line count). The stride alignment rule then does not apply.
- R6: A request is rejected when the line count or line length is zero, when the line count after merging exceeds 2048, or when line count × memory stride exceeds 16777216.
- R7: A request is rejected when the memory stride is below the line length, when the device stride's magnitude is below the line length, or when memory stride minus line length is 4096 or more.
- R8: A request is rejected when the memory address is not a multiple of 16 or the device address is not a multiple of 4. With more than one line, it is also rejected when the memory stride is not a multiple of 16 or the device stride is not a multiple of 4.
- R9: A rejected request writes no word and produces a done pulse with the error flag at 1, count 0 and head 0.
- R10: Busy rises the cycle after start is accepted and stays high through the done cycle, then drops. Done is high for exactly one cycle. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept a request (ignored while busy) |
| base_addr | input | 32 | Base of the descriptor area (16-byte aligned) |
| mem_addr | input | 32 | System-memory start address |
| dev_addr | input | 32 | Device-side start address |
| line_len | input | LEN_W | Bytes per line |
| line_cnt | input | LINES_W | Number of lines |
| mem_stride | input | STR_W | System-memory stride in bytes |
| dev_stride | input | STR_W+1 | Signed device-side stride in bytes |
| busy | output | 1 | Request in progress |
| wr_en | output | 1 | Descriptor word write strobe |
| wr_addr | output | 32 | Byte address of the word written |
| wr_data | output | 32 | Word written |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request was rejected (valid with done) |
| done_count | output | CNT_W | Descriptors written (valid with done) |
| done_head | output | 32 | Chain head address (valid with done) |

## Verification
The assertions assume that the descriptor base is a multiple of 16 and does not change while busy. They also assume that the descriptor count of any accepted request fits in CNT_W bits. The bench sets every base it uses to a multiple of 16, draws line lengths below 9000 bytes and line counts of at most a few lines, and keeps the largest directed request at 2048 one-segment lines. This keeps the count far below the counter limit. Random requests are steered toward page-crossing start offsets and negative device strides, and a fraction of them are corrupted on purpose so that the rejection paths are also exercised.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

  localparam int PAGE_W = 12;
  localparam logic [31:0] PAGE_BYTES = 32'd1 << PAGE_W;
  localparam logic [31:0] EOC_FLAG = 32'h0000_0002;

  typedef struct packed {
    logic [31:0] mem;
    logic [31:0] dev;
    logic [31:0] size;
    logic [31:0] nxt;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_SEG   = 3'd2,
    S_EMIT  = 3'd3,
    S_DONE  = 3'd4
  } walk_state_t;

  // bytes from addr to the end of its page, capped by what the line still needs
  function automatic logic [31:0] seg_bytes(input logic [31:0] addr, input logic [31:0] left);
    logic [31:0] room;
    room = PAGE_BYTES - {{(32-PAGE_W){1'b0}}, addr[PAGE_W-1:0]};
    return (room < left) ? room : left;
  endfunction

  function automatic logic [31:0] slot_of(input logic [31:0] base, input logic [31:0] idx);
    return base + (idx << 4);
  endfunction

endpackage

// File: rtl/sdg_validate.sv
module sdg_validate #(
  parameter int LEN_W     = 16,
  parameter int LINES_W   = 12,
  parameter int STR_W     = 16,
  parameter int MAX_LINES = 2048,
  parameter int MAX_BYTES = 16777216
) (
  input  logic [31:0]        mem_addr,
  input  logic [31:0]        dev_addr,
  input  logic [LEN_W-1:0]   len,
  input  logic [LINES_W-1:0] lines,
  input  logic [STR_W-1:0]   mstride,
  input  logic [STR_W:0]     dstride,
  output logic               ok,
  output logic [31:0]        eff_len,
  output logic [LINES_W-1:0] eff_lines,
  output logic [31:0]        eff_ms,
  output logic [31:0]        eff_ds
);

  logic [31:0] len32, ms32, ds32, lines32, dmag, eff_lines32, bytes;
  logic        merge;
  logic        f_zero, f_gap, f_many, f_big, f_stride, f_align;

  always_comb begin
    len32   = {{(32-LEN_W){1'b0}}, len};
    ms32    = {{(32-STR_W){1'b0}}, mstride};
    ds32    = {{(31-STR_W){dstride[STR_W]}}, dstride};
    lines32 = {{(32-LINES_W){1'b0}}, lines};
    merge   = (ms32 == len32) && (ds32 == len32);

    if (merge) begin
      eff_len   = len32 * lines32;
      eff_lines = LINES_W'(1);
      eff_ms    = eff_len;
      eff_ds    = eff_len;
    end else begin
      eff_len   = len32;
      eff_lines = lines;
      eff_ms    = ms32;
      eff_ds    = ds32;
    end
    eff_lines32 = {{(32-LINES_W){1'b0}}, eff_lines};
    dmag        = eff_ds[31] ? (32'd0 - eff_ds) : eff_ds;
    bytes       = eff_lines32 * eff_ms;

    f_zero   = (len32 == 32'd0) || (lines32 == 32'd0);
    f_gap    = (ms32 < len32) || ((ms32 - len32) >= sdg_pkg::PAGE_BYTES);
    f_many   = eff_lines32 > 32'(MAX_LINES);
    f_big    = bytes > 32'(MAX_BYTES);
    f_stride = (eff_ms < eff_len) || (dmag < eff_len);
    f_align  = (mem_addr[3:0] != 4'd0) || (dev_addr[1:0] != 2'd0) ||
               ((eff_lines32 > 32'd1) && ((eff_ms[3:0] != 4'd0) || (eff_ds[1:0] != 2'd0)));
    ok = !(f_zero || f_gap || f_many || f_big || f_stride || f_align);
  end

  always_comb begin
    AST_OK_ALIGNED: assert (!ok || (mem_addr[3:0] == 4'd0 && dev_addr[1:0] == 2'd0)); // R8
  end

endmodule

// File: rtl/sdg_emit.sv
module sdg_emit (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [31:0]    slot,
  input  sdg_pkg::desc_t desc,
  output logic           wr_en,
  output logic [31:0]    wr_addr,
  output logic [31:0]    wr_data,
  output logic           last
);

  logic           active;
  logic [1:0]     widx;
  logic [31:0]    slot_q;
  sdg_pkg::desc_t desc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      widx   <= 2'd0;
      slot_q <= 32'd0;
      desc_q <= '0;
    end else if (load) begin
      active <= 1'b1;
      widx   <= 2'd0;
      slot_q <= slot;
      desc_q <= desc;
    end else if (active) begin
      widx <= widx + 2'd1;
      if (widx == 2'd3) active <= 1'b0;
    end
  end

  always_comb begin
    wr_en   = active;
    wr_addr = slot_q + {28'd0, widx, 2'b00};
    last    = active && (widx == 2'd3);
    unique case (widx)
      2'd0: wr_data = desc_q.mem;
      2'd1: wr_data = desc_q.dev;
      2'd2: wr_data = desc_q.size;
      default: wr_data = desc_q.nxt;
    endcase
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active); // R1
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !last) |=> (wr_en && wr_addr == $past(wr_addr) + 32'd4)); // R1
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[1:0] == 2'd0)); // R1

endmodule

// File: rtl/stride_desc_chain.sv
module stride_desc_chain #(
  parameter int LEN_W     = 16,
  parameter int LINES_W   = 12,
  parameter int STR_W     = 16,
  parameter int CNT_W     = 16,
  parameter int MAX_LINES = 2048,
  parameter int MAX_BYTES = 16777216
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        base_addr,
  input  logic [31:0]        mem_addr,
  input  logic [31:0]        dev_addr,
  input  logic [LEN_W-1:0]   line_len,
  input  logic [LINES_W-1:0] line_cnt,
  input  logic [STR_W-1:0]   mem_stride,
  input  logic [STR_W:0]     dev_stride,
  output logic               busy,
  output logic               wr_en,
  output logic [31:0]        wr_addr,
  output logic [31:0]        wr_data,
  output logic               done,
  output logic               done_err,
  output logic [CNT_W-1:0]   done_count,
  output logic [31:0]        done_head
);
  import sdg_pkg::*;

  walk_state_t state;

  logic [31:0]        r_mem, r_dev, base_q;
  logic [LEN_W-1:0]   r_len;
  logic [LINES_W-1:0] r_lines;
  logic [STR_W-1:0]   r_ms;
  logic [STR_W:0]     r_ds;

  logic               req_ok;
  logic [31:0]        eff_len, eff_ms, eff_ds;
  logic [LINES_W-1:0] eff_lines;

  logic [31:0]        cur_mem, cur_dev, line_mem, line_dev, left, len_q, ms_q, ds_q;
  logic [31:0]        prev_ptr, seg_q;
  logic [LINES_W-1:0] lines_left;
  logic [CNT_W-1:0]   idx;
  logic               err_q;

  // named internal events
  logic        seg_load, emit_last, line_end, walk_end, check_fail;
  logic [31:0] seg_now, slot_now;
  desc_t       desc_now;

  sdg_validate #(
    .LEN_W(LEN_W), .LINES_W(LINES_W), .STR_W(STR_W),
    .MAX_LINES(MAX_LINES), .MAX_BYTES(MAX_BYTES)
  ) u_validate (
    .mem_addr (r_mem),
    .dev_addr (r_dev),
    .len      (r_len),
    .lines    (r_lines),
    .mstride  (r_ms),
    .dstride  (r_ds),
    .ok       (req_ok),
    .eff_len  (eff_len),
    .eff_lines(eff_lines),
    .eff_ms   (eff_ms),
    .eff_ds   (eff_ds)
  );

  always_comb begin
    seg_load   = (state == S_SEG);
    check_fail = (state == S_CHECK) && !req_ok;
    seg_now    = seg_bytes(cur_mem, left);
    slot_now   = slot_of(base_q, {{(32-CNT_W){1'b0}}, idx});
    desc_now   = '{mem: cur_mem, dev: cur_dev, size: seg_now, nxt: prev_ptr};
    line_end   = emit_last && (left == seg_q);
    walk_end   = line_end && (lines_left == LINES_W'(1));
  end

  sdg_emit u_emit (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (seg_load),
    .slot   (slot_now),
    .desc   (desc_now),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .last   (emit_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      r_mem      <= '0; r_dev <= '0; base_q <= '0;
      r_len      <= '0; r_lines <= '0; r_ms <= '0; r_ds <= '0;
      cur_mem    <= '0; cur_dev <= '0; line_mem <= '0; line_dev <= '0;
      left       <= '0; len_q <= '0; ms_q <= '0; ds_q <= '0;
      prev_ptr   <= '0; seg_q <= '0; lines_left <= '0; idx <= '0; err_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          r_mem   <= mem_addr;
          r_dev   <= dev_addr;
          r_len   <= line_len;
          r_lines <= line_cnt;
          r_ms    <= mem_stride;
          r_ds    <= dev_stride;
          base_q  <= base_addr;
          state   <= S_CHECK;
        end
        S_CHECK: begin
          idx <= '0;
          if (req_ok) begin
            cur_mem    <= r_mem;
            cur_dev    <= r_dev;
            line_mem   <= r_mem;
            line_dev   <= r_dev;
            left       <= eff_len;
            len_q      <= eff_len;
            lines_left <= eff_lines;
            ms_q       <= eff_ms;
            ds_q       <= eff_ds;
            prev_ptr   <= EOC_FLAG;
            err_q      <= 1'b0;
            state      <= S_SEG;
          end else begin
            prev_ptr <= '0;
            err_q    <= 1'b1;
            state    <= S_DONE;
          end
        end
        S_SEG: begin
          seg_q <= seg_now;
          state <= S_EMIT;
        end
        S_EMIT: if (emit_last) begin
          prev_ptr <= slot_now;
          idx      <= idx + CNT_W'(1);
          if (walk_end) begin
            state <= S_DONE;
          end else if (line_end) begin
            line_mem   <= line_mem + ms_q;
            line_dev   <= line_dev + ds_q;
            cur_mem    <= line_mem + ms_q;
            cur_dev    <= line_dev + ds_q;
            left       <= len_q;
            lines_left <= lines_left - LINES_W'(1);
            state      <= S_SEG;
          end else begin
            cur_mem <= cur_mem + seg_q;
            cur_dev <= cur_dev + seg_q;
            left    <= left - seg_q;
            state   <= S_SEG;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state != S_IDLE);
    done       = (state == S_DONE);
    done_err   = done && err_q;
    done_count = done ? idx : '0;
    done_head  = done ? prev_ptr : '0;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R10
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    check_fail |=> (done && done_err && !wr_en && done_count == '0)); // R9
  AST_SEG_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_load |-> (seg_now != 32'd0 &&
                  ({20'd0, cur_mem[11:0]} + seg_now) <= PAGE_BYTES && seg_now <= left)); // R2
  AST_FIRST_ENDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_load && idx == '0) |-> (prev_ptr == EOC_FLAG)); // R4
  AST_HEAD_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (done_count != '0 &&
      done_head == base_q + (({{(32-CNT_W){1'b0}}, done_count} - 32'd1) << 4))); // R4

endmodule

// File: tb/stride_desc_chain_tb.sv
module stride_desc_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16, LINES_W = 12, STR_W = 16, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base_addr = '0, mem_addr = '0, dev_addr = '0;
  logic [LEN_W-1:0] line_len = '0;
  logic [LINES_W-1:0] line_cnt = '0;
  logic [STR_W-1:0] mem_stride = '0;
  logic [STR_W:0] dev_stride = '0;
  logic busy, wr_en, done, done_err;
  logic [31:0] wr_addr, wr_data, done_head;
  logic [CNT_W-1:0] done_count;

  int n_tests = 0, n_fail = 0;
  int wcount = 0;
  logic [31:0] wmem [logic [31:0]];
  int unsigned e_word [$];
  bit e_ok;
  longint e_head;
  int e_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  stride_desc_chain #(.LEN_W(LEN_W), .LINES_W(LINES_W), .STR_W(STR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .mem_addr(mem_addr), .dev_addr(dev_addr), .line_len(line_len), .line_cnt(line_cnt),
    .mem_stride(mem_stride), .dev_stride(dev_stride), .busy(busy), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .done_err(done_err),
    .done_count(done_count), .done_head(done_head));

  always @(negedge clk) if (wr_en) begin
    wmem[wr_addr] = wr_data;
    wcount++;
  end

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // reference model, written from the requirements
  task automatic model(input longint base, input longint ma, input longint da, input longint len,
                       input longint nl, input longint ms, input longint ds);
    longint m, d, rem, s, room, prev, slot;
    bit bad;
    e_word.delete();
    bad = 0;
    if (len == 0 || nl == 0) bad = 1;                                  // R6
    if (ms < len || ms - len >= 4096) bad = 1;                         // R7
    if (ms == len && ds == len) begin len = len * nl; ms = len; ds = len; nl = 1; end // R5
    if (nl > 2048 || nl * ms > 16777216) bad = 1;                      // R6
    if (ms < len || (ds < 0 ? -ds : ds) < len) bad = 1;                // R7
    if ((ma % 16) != 0 || (da % 4) != 0) bad = 1;                      // R8
    if (nl > 1 && ((ms % 16) != 0 || (ds & 3) != 0)) bad = 1;         // R8
    e_ok = !bad;
    e_count = 0;
    e_head = 0;
    if (bad) return;
    prev = 2;
    for (longint ln = 0; ln < nl; ln++) begin
      m = (ma + ln * ms) & 64'hFFFF_FFFF;                              // R3
      d = (da + ln * ds) & 64'hFFFF_FFFF;
      rem = len;
      while (rem > 0) begin
        room = 4096 - (m % 4096);                                      // R2
        s = (room < rem) ? room : rem;
        e_word.push_back(32'(m)); e_word.push_back(32'(d));
        e_word.push_back(32'(s)); e_word.push_back(32'(prev));
        slot = (base + 16 * e_count) & 64'hFFFF_FFFF;
        prev = slot;
        e_count++;
        m = (m + s) & 64'hFFFF_FFFF;
        d = (d + s) & 64'hFFFF_FFFF;
        rem -= s;
      end
    end
    e_head = prev;
  endtask

  task automatic run_job(input string tag, input logic [31:0] base, input logic [31:0] ma,
                         input logic [31:0] da, input int len, input int nl, input int ms,
                         input int ds, input bit poke);
    int mism;
    logic [31:0] a;
    model(longint'(base), longint'(ma), longint'(da), len, nl, ms, ds);
    wmem.delete();
    wcount = 0;
    @(negedge clk);
    base_addr = base; mem_addr = ma; dev_addr = da;
    line_len = LEN_W'(len); line_cnt = LINES_W'(nl);
    mem_stride = STR_W'(ms); dev_stride = (STR_W+1)'(ds);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {tag, " R10 busy after start"}, busy, 1);
    if (poke) begin
      @(negedge clk);
      line_cnt = '0; mem_addr = 32'h3; start = 1'b1;  // must be ignored: R10
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    check(done_err === !e_ok, {tag, " error flag R6 R7 R8"}, done_err, !e_ok);
    check(done_count == CNT_W'(e_count), {tag, " count R4"}, done_count, e_count);
    check(done_head == 32'(e_head), {tag, " head R4"}, done_head, e_head);
    check(wcount == 4 * e_count, {tag, " word writes R1 R9"}, wcount, 4 * e_count);
    mism = 0;
    for (int i = 0; i < e_word.size(); i++) begin
      a = base + 32'(4 * i);
      if (!wmem.exists(a) || wmem[a] !== e_word[i]) begin
        if (mism == 0)
          check(0, {tag, $sformatf(" word %0d R1 R2 R3 R4", i)}, wmem.exists(a) ? wmem[a] : 0, e_word[i]);
        mism++;
      end
    end
    if (mism == 0) check(1, tag, 0, 0);
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, {tag, " R10 idle after done"}, {busy, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int len, nl, ms, ds, k;
    logic [31:0] ma, da, base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0, "reset state R10", {busy, done, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_job("single in-page R1 R2", 32'h0000_8000, 32'h1000_0100, 32'h0000_0040, 256, 1, 256, 512, 0);
    run_job("page split R2", 32'h0000_8000, 32'h1000_0FF0, 32'h0000_0000, 48, 2, 64, 64, 0);
    run_job("flip negative stride R3", 32'h0001_0000, 32'h2000_0F00, 32'h0004_0000, 512, 4, 512, -512, 0);
    run_job("merged contiguous R5", 32'h0002_0000, 32'h3000_0FC0, 32'h0000_1000, 64, 200, 64, 64, 0);
    run_job("merged odd stride R5", 32'h0002_0000, 32'h3000_0000, 32'h0000_0000, 20, 3, 20, 20, 0);
    run_job("zero lines R6 R9", 32'h0003_0000, 32'h0, 32'h0, 64, 0, 64, 64, 0);
    run_job("zero length R6 R9", 32'h0003_0000, 32'h0, 32'h0, 0, 4, 64, 64, 0);
    run_job("2048 lines ok R6", 32'h0004_0000, 32'h4000_0000, 32'h0, 16, 2048, 16, 32, 0);
    run_job("2049 lines R6", 32'h0004_0000, 32'h4000_0000, 32'h0, 16, 2049, 16, 32, 0);
    run_job("over 16MiB R6", 32'h0004_0000, 32'h0, 32'h0, 65520, 300, 65520, 65524, 0);
    run_job("mem stride short R7", 32'h0005_0000, 32'h0, 32'h0, 64, 2, 48, 64, 0);
    run_job("dev stride short R7", 32'h0005_0000, 32'h0, 32'h0, 64, 2, 64, -60, 0);
    run_job("gap 4096 R7", 32'h0005_0000, 32'h0, 32'h0, 16, 2, 4112, 16, 0);
    run_job("gap 4080 ok R7", 32'h0005_0000, 32'h0, 32'h0, 32, 2, 4112, 32, 0);
    run_job("mem addr misaligned R8", 32'h0006_0000, 32'h8, 32'h0, 64, 2, 64, 128, 0);
    run_job("dev addr misaligned R8", 32'h0006_0000, 32'h0, 32'h2, 64, 2, 64, 128, 0);
    run_job("stride misaligned R8", 32'h0006_0000, 32'h0, 32'h0, 64, 2, 72, 128, 0);
    run_job("dev stride misaligned R8", 32'h0006_0000, 32'h0, 32'h0, 64, 2, 64, 130, 0);
    run_job("start while busy R10", 32'h0007_0000, 32'h5000_0FE0, 32'h0, 100, 3, 112, 100, 1);

    for (int j = 0; j < 40; j++) begin
      len  = 1 + int'($urandom % 9000);
      nl   = 1 + int'($urandom % 5);
      ms   = ((len + 15) / 16) * 16 + 16 * int'($urandom % 8);
      ds   = ((len + 3) / 4) * 4 + 4 * int'($urandom % 8);
      if ($urandom % 3 == 0) ds = -ds;
      ma   = {$urandom, 4'h0} >> 4;
      ma   = {ma[31:12], 12'h0} | (($urandom % 2 == 0) ? 32'hFE0 : {20'h0, $urandom} & 32'hFF0);
      da   = $urandom & 32'hFFFF_FFFC;
      base = $urandom & 32'hFFFF_FFF0;
      k = int'($urandom % 10);
      if (k == 0) ma = ma | 32'h4;
      if (k == 1) ms = len - 1;
      if (k == 2) ds = ds + 2;
      run_job($sformatf("random %0d R1 R2 R3 R4", j), base, ma, da, len, nl, ms, ds, 0);
    end

    summary();
  end

endmodule